// File: doc/BRIEF.md
# Single-Wire Byte Transmitter with Collision Detection

This block sends bytes over one shared, bidirectional data line, in step with an external serial clock. Each accepted byte becomes a twelve-bit frame. The transmitter turns its line driver on only in a bit period whose value differs from the bit before it. When a value repeats, it turns the driver off and lets an external bus keeper hold the line. It then reads the line back to see whether some other driver has pulled it the wrong way.

A mismatch found in such a read-back period sets a sticky collision flag. It also abandons the frame under way and leaves the line released until the flag is cleared. Every frame ends in two stop bits of one, so at least one read-back happens in each frame, even when the data bits alternate. The line's output register changes on the falling clock edge, and the read-back is sampled on the rising edge.

Top module: `swire_tx`

## Requirements
- R1: A frame is twelve bit periods: a start bit of 0, then the eight data bits with bit 0 first, then one parity bit that makes the count of ones across data and parity even, then two stop bits of 1.
- R2: `line_oe` is high in a bit period exactly when that period's bit differs from the bit of the period before it. After reset, between frames and after an abort, the previous bit counts as 1, so a start bit is always driven.
- R3: In a frame bit period with `line_oe` low, `line_in` is sampled at the rising edge. If it differs from `line_out`, `coll_flag` is 1 after that edge.
- R4: In a bit period with `line_oe` high, the level on `line_in` has no effect on `coll_flag`.
- R5: `coll_flag` stays 1 until a rising edge that samples `coll_clr` high while no new mismatch is seen. A mismatch at the same edge as a clear leaves the flag set.
- R6: While `coll_flag` is 1, the next falling edge ends the frame: `line_oe` goes low with `line_out` at 1, and `tx_ready` is low.
- R7: `tx_ready` is high only when no frame is in progress (or its last stop bit is on the line) and `coll_flag` is 0. A falling edge that samples `tx_valid` and `tx_ready` both high takes `tx_byte`, and the start bit appears from the following falling edge.
- R8: With `tx_valid` held high, two frames are taken 13 clock cycles apart, which leaves one idle period between the last stop bit and the next start bit.
- R9: After reset, `line_oe` is 0, `line_out` is 1, `coll_flag` is 0 and `tx_ready` is 1.
- R10: Changes on `tx_byte` and `tx_valid` while a frame is in progress do not alter the frame on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the external programmer |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with sclk |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_byte holds a byte to send |
| tx_ready | output | 1 | Transmitter can take a byte |
| line_out | output | 1 | Value driven on the shared line |
| line_oe | output | 1 | Line driver enable |
| line_in | input | 1 | Level read back from the shared line |
| coll_flag | output | 1 | Sticky collision indication |
| coll_clr | input | 1 | Clears coll_flag |

## Verification
Line outputs move at a falling edge, one clock period after the falling edge that took the byte or drove the previous bit. The collision flag moves at the rising edge inside the read-back period, and the abort follows at the next falling edge. A clear takes effect at the rising edge that samples it. The bench runs a bit-queue model that advances on the same edges. It compares all four outputs two nanoseconds before each rising edge, when every value due in that period has settled. The directed checks for flag, abort and clear are also taken at points counted in edges from the stimulus.

// File: rtl/swire_pkg.sv
`timescale 1ns/1ps
package swire_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_SEND} seq_state_e;

  // frame field lengths in bit periods
  localparam int START_LEN = 1;
  localparam int PAR_LEN   = 1;
  localparam int STOP_LEN  = 2;

  // level the keeper holds between frames
  localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/swire_rst_sync.sv
`timescale 1ns/1ps
module swire_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/swire_frame_seq.sv
`timescale 1ns/1ps
module swire_frame_seq
  import swire_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              abort_i,
  output logic              bit_o,
  output logic              drive_o,
  output logic              rpt_o
);
  localparam int FRAME_W = START_LEN + DATA_W + PAR_LEN + STOP_LEN;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  seq_state_e         state_q, state_d;
  logic [CNT_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic               prev_q, prev_d;
  logic               bit_q, bit_d;
  logic               drive_q, drive_d;
  logic               rpt_q, rpt_d;
  logic               take, shift_en, cur;

  assign ready_o  = (state_q == SEQ_IDLE) && !abort_i;
  assign take     = valid_i && ready_o;
  assign cur      = shift_q[0];
  assign shift_en = take || (state_q == SEQ_SEND);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    prev_d  = prev_q;
    bit_d   = LINE_IDLE;
    drive_d = 1'b0;
    rpt_d   = 1'b0;
    if (take) shift_d = {{STOP_LEN{1'b1}}, ^data_i, data_i, 1'b0};
    else      shift_d = shift_q >> 1;

    if (abort_i) begin
      state_d = SEQ_IDLE;
      idx_d   = '0;
      prev_d  = LINE_IDLE;
    end else if (state_q == SEQ_SEND) begin
      bit_d   = cur;
      drive_d = (cur != prev_q);
      rpt_d   = (cur == prev_q);
      prev_d  = cur;
      if (idx_q == LAST_IDX) begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (take) begin
      state_d = SEQ_SEND;
      idx_d   = '0;
      prev_d  = LINE_IDLE;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      prev_q  <= LINE_IDLE;
      bit_q   <= LINE_IDLE;
      drive_q <= 1'b0;
      rpt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      prev_q  <= prev_d;
      bit_q   <= bit_d;
      drive_q <= drive_d;
      rpt_q   <= rpt_d;
    end
  end

  // datapath register: no reset, explicit enable
  always_ff @(negedge clk) begin
    if (shift_en) shift_q <= shift_d;
  end

  assign bit_o   = bit_q;
  assign drive_o = drive_q;
  assign rpt_o   = rpt_q;
endmodule

// File: rtl/swire_line_mon.sv
`timescale 1ns/1ps
module swire_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic rpt_i,
  input  logic exp_i,
  input  logic line_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, clash;

  assign clash = rpt_i && (line_i != exp_i);

  always_comb begin
    flag_d = flag_q;
    if (clash)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/swire_tx.sv
`timescale 1ns/1ps
module swire_tx #(
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              line_out,
  output logic              line_oe,
  input  logic              line_in,
  output logic              coll_flag,
  input  logic              coll_clr
);
  logic srst_n;
  logic rpt_chk;

  swire_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (sclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  swire_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (sclk),
    .rst_n   (srst_n),
    .data_i  (tx_byte),
    .valid_i (tx_valid),
    .ready_o (tx_ready),
    .abort_i (coll_flag),
    .bit_o   (line_out),
    .drive_o (line_oe),
    .rpt_o   (rpt_chk)
  );

  swire_line_mon u_mon (
    .clk    (sclk),
    .rst_n  (srst_n),
    .rpt_i  (rpt_chk),
    .exp_i  (line_out),
    .line_i (line_in),
    .clr_i  (coll_clr),
    .flag_o (coll_flag)
  );
endmodule

// File: rtl/swire_tx_chk.sv
`timescale 1ns/1ps
module swire_tx_chk (
  input logic sclk,
  input logic rst_n,
  input logic tx_ready,
  input logic line_out,
  input logic line_oe,
  input logic line_in,
  input logic coll_flag,
  input logic coll_clr,
  input logic rpt_chk
);
  // R2
  oe_on_change_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    line_oe |-> (line_out != $past(line_out)));

  // R3
  readback_clash_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (rpt_chk && !line_oe && (line_in != line_out)) |=> coll_flag);

  // R5
  flag_sticky_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (coll_flag && !coll_clr) |=> coll_flag);

  // R6
  abort_release_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    coll_flag |=> (!line_oe && line_out));

  // R7
  ready_blocked_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    coll_flag |-> !tx_ready);

  // R7
  ready_quiet_line_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    tx_ready |-> !line_oe);
endmodule

bind swire_tx swire_tx_chk u_chk (.*);

// File: tb/test_swire_tx.sv
`timescale 1ns/1ps
module test_swire_tx;
  logic       sclk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_byte;
  logic       tx_valid;
  logic       tx_ready;
  logic       line_out;
  logic       line_oe;
  wire        line_in;
  logic       coll_flag;
  logic       coll_clr;
  logic       ext_en, ext_val;
  logic       keeper = 1'b1;

  int checks   = 0;
  int failures = 0;
  bit cmp_on   = 1'b0;
  bit finished = 1'b0;

  // reference model state
  logic q[$];
  logic e_out = 1'b1, e_oe = 1'b0, m_chk = 1'b0, m_prev = 1'b1, m_coll = 1'b0;

  swire_tx i_swire_tx (
    .sclk(sclk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_out(line_out), .line_oe(line_oe),
    .line_in(line_in), .coll_flag(coll_flag), .coll_clr(coll_clr)
  );

  always #10 sclk = ~sclk;

  // shared line: external driver wins, else our driver, else the keeper
  always @(line_oe or line_out) if (line_oe) keeper = line_out;
  assign line_in = ext_en ? ext_val : (line_oe ? line_out : keeper);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // model: falling edge moves the line
  always @(negedge sclk) begin
    if (m_coll) begin
      q.delete();
      e_out = 1'b1; e_oe = 1'b0; m_chk = 1'b0; m_prev = 1'b1;
    end else if (q.size() != 0) begin
      logic b;
      b = q.pop_front();
      e_out = b; e_oe = (b != m_prev); m_chk = (b == m_prev); m_prev = b;
    end else begin
      e_out = 1'b1; e_oe = 1'b0; m_chk = 1'b0; m_prev = 1'b1;
      if (tx_valid === 1'b1) begin
        int ones;
        ones = 0;
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) begin
          q.push_back(tx_byte[i]);
          ones += int'(tx_byte[i]);
        end
        q.push_back(logic'(ones % 2));
        q.push_back(1'b1);
        q.push_back(1'b1);
      end
    end
  end

  // model: rising edge reads back the line
  always @(posedge sclk) begin
    if (m_chk && (line_in !== e_out)) m_coll = 1'b1;
    else if (coll_clr)                m_coll = 1'b0;
  end

  // per-cycle comparison, 2 ns before the rising edge
  always @(negedge sclk) begin
    #8;
    if (cmp_on) begin
      check(line_oe === e_oe, "R2 line_oe", int'(line_oe), int'(e_oe));
      check(line_out === e_out, "R1 line_out", int'(line_out), int'(e_out));
      check(coll_flag === m_coll, "R3/R5 coll_flag", int'(coll_flag), int'(m_coll));
      check(tx_ready === ((q.size() == 0) && !m_coll), "R7 tx_ready",
            int'(tx_ready), int'((q.size() == 0) && !m_coll));
    end
  end

  task automatic send(input logic [7:0] b, output time t_acc);
    tx_byte  = b;
    tx_valid = 1'b1;
    forever begin
      @(posedge sclk); #5;
      if (tx_ready) begin
        @(negedge sclk);
        break;
      end
    end
    t_acc = $time;
    #1 tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(posedge sclk); while (!tx_ready);
    repeat (2) @(posedge sclk);
    #2;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    time t0, t1;
    rst_n = 1'b0; tx_valid = 1'b0; tx_byte = 8'h00; coll_clr = 1'b0;
    ext_en = 1'b0; ext_val = 1'b0;
    repeat (3) @(posedge sclk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge sclk);
    #2;
    // R9 reset state
    check(line_oe === 1'b0, "R9 line_oe", int'(line_oe), 0);
    check(line_out === 1'b1, "R9 line_out", int'(line_out), 1);
    check(coll_flag === 1'b0, "R9 coll_flag", int'(coll_flag), 0);
    check(tx_ready === 1'b1, "R9 tx_ready", int'(tx_ready), 1);
    cmp_on = 1'b1;

    // R1 R2 several byte patterns
    send(8'h55, t0); wait_idle();
    send(8'h00, t0); wait_idle();
    send(8'hFF, t0); wait_idle();
    send(8'h01, t0); wait_idle();
    send(8'h80, t0); wait_idle();

    // R8 back-to-back, R10 byte changes while busy
    send(8'hA5, t0);
    #2 tx_byte = 8'h0F; tx_valid = 1'b1;
    repeat (3) @(posedge sclk);
    send(8'h3C, t1);
    check((t1 - t0) == 260, "R8 accept spacing ns", int'(t1 - t0), 260);
    wait_idle();

    // R4 external driver against a driven bit
    send(8'h55, t0);
    @(negedge sclk); @(negedge sclk); @(negedge sclk);
    #2 ext_en = 1'b1; ext_val = 1'b1;
    @(negedge sclk); #2 ext_en = 1'b0;
    wait_idle();
    check(coll_flag === 1'b0, "R4 no clash on driven bit", int'(coll_flag), 0);

    // R3 R6 clash in a repeated bit
    send(8'h00, t0);
    @(negedge sclk); @(negedge sclk);
    #2 ext_en = 1'b1; ext_val = 1'b1;
    @(negedge sclk); #2 ext_en = 1'b0;
    #5;
    check(coll_flag === 1'b1, "R3 flag set", int'(coll_flag), 1);
    check(line_oe === 1'b0, "R6 line released", int'(line_oe), 0);
    check(tx_ready === 1'b0, "R6 ready low", int'(tx_ready), 0);
    tx_byte = 8'h33; tx_valid = 1'b1;
    repeat (4) @(posedge sclk);
    #2 tx_valid = 1'b0;
    check(coll_flag === 1'b1, "R5 flag held", int'(coll_flag), 1);
    check(line_oe === 1'b0, "R6 no frame while flagged", int'(line_oe), 0);
    coll_clr = 1'b1;
    @(posedge sclk); #2 coll_clr = 1'b0;
    check(coll_flag === 1'b0, "R5 flag cleared", int'(coll_flag), 0);
    check(tx_ready === 1'b1, "R7 ready after clear", int'(tx_ready), 1);
    repeat (2) @(posedge sclk); #2;

    // R5 set wins over a simultaneous clear
    send(8'hFF, t0);
    @(negedge sclk); @(negedge sclk); @(negedge sclk);
    #2 ext_en = 1'b1; ext_val = 1'b0; coll_clr = 1'b1;
    @(negedge sclk); #2 ext_en = 1'b0; coll_clr = 1'b0;
    #5;
    check(coll_flag === 1'b1, "R5 set beats clear", int'(coll_flag), 1);
    @(posedge sclk); #2 coll_clr = 1'b1;
    @(posedge sclk); #2 coll_clr = 1'b0;
    check(coll_flag === 1'b0, "R5 cleared again", int'(coll_flag), 0);

    send(8'h96, t0); wait_idle();
    finished = 1'b1;
    report();
  end
endmodule